// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receiving half of a clocked serial port that acts as bus master. It makes the shift clock itself, from a programmable divider on the system clock, and reads one serial data line that a slave updates while that clock is high. Each word is 8 bits, or 9 bits when the wide mode is on. Bits arrive least-significant first and are captured on the falling edge of the shift clock.

Software starts a transfer in one of two ways. A one-shot enable takes a single word and then clears itself. A continuous enable keeps words coming until it is dropped, and it wins when both are set. Each completed word goes into a two-entry queue. The consumer drains the queue through a valid/ready read port that shows the head byte and its ninth bit together. The data-ready flag and its maskable interrupt follow queue occupancy.

A word that completes while the queue is full raises a sticky overrun flag, and that word is lost. While overrun is set, no word enters the queue. Overrun clears only after the continuous enable is taken low.

Top module: `sync_master_rx`

## Requirements
- R1: After reset the shift clock is low, the queue is empty (read valid low), and the ready, interrupt, overrun and one-shot enable outputs are all low.
- R2: While the port enable is high and either receive enable is active, the shift clock toggles every div_i+1 system clocks, giving a full period of 2*(div_i+1) clocks. In any other case it is held low.
- R3: Each data bit is sampled on a falling edge of the shift clock, least-significant bit first. A word is complete after 8 samples, or after 9 samples when nine_bit_i is high.
- R4: Pulsing single_set_i sets the one-shot enable. It receives exactly one word and then clears itself; single_en_o reads its state.
- R5: With cont_en_i high, words are received back to back until cont_en_i goes low. When both enables are set, reception continues past the first word.
- R6: The queue holds two words. rd_valid_o is high while the queue is not empty, and a word is removed on a cycle where rd_valid_o and rd_ready_i are both high. While rd_ready_i is low, rd_valid_o and the head data stay unchanged.
- R7: rx_ready_o is high exactly while the queue holds a word. irq_o is rx_ready_o AND irq_en_i.
- R8: When a word completes with the queue full, overrun_o goes high and that word is discarded. Words already queued are kept in order.
- R9: overrun_o stays high while cont_en_i is high, and while it is high no word enters the queue. It clears on the cycle after cont_en_i falls.
- R10: In 9-bit mode, the ninth received bit (bit 8 of the word) travels with its byte and appears on rd_bit9_o while that byte is at the head. In 8-bit mode, rd_bit9_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en_i | input | 1 | Serial port enable |
| cont_en_i | input | 1 | Continuous receive enable (level) |
| single_set_i | input | 1 | One-cycle pulse that arms a one-shot word |
| nine_bit_i | input | 1 | 1 = 9-bit words, 0 = 8-bit words |
| div_i | input | DIV_W | Baud divider value |
| irq_en_i | input | 1 | Receive interrupt enable |
| sclk_o | output | 1 | Generated shift clock |
| sdata_i | input | 1 | Serial data line |
| rd_valid_o | output | 1 | Queue head is valid |
| rd_ready_i | input | 1 | Consumer accepts the head word |
| rd_data_o | output | 8 | Head data byte |
| rd_bit9_o | output | 1 | Ninth bit belonging to the head byte |
| rx_ready_o | output | 1 | Data-ready flag |
| irq_o | output | 1 | Receive interrupt |
| overrun_o | output | 1 | Sticky overrun flag |
| single_en_o | output | 1 | One-shot enable state |

## Verification
The bench builds the block with DIV_W=4 and FIFO_DEPTH=2. The narrow divider lets the vector table cover divider values 0 to 3, so bit spacing from 2 to 8 clocks is exercised with both word lengths. A queue of two entries overflows on the third word of a continuous burst, so the overrun, discard and blocked-load paths are reached within a few dozen clocks.

// File: rtl/smrx_pkg.sv
package smrx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SHIFT_W = BYTE_W + 1;

  typedef struct packed {
    logic              bit9;
    logic [BYTE_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/smrx_baud.sv
module smrx_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick   = (cnt_q == div_i);
  assign fall_o = run_i && tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/smrx_shifter.sv
module smrx_shifter
  import smrx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_i,
  input  logic     fall_i,
  input  logic     nine_i,
  input  logic     sdata_i,
  output logic     done_o,
  output rx_word_t word_o
);
  localparam int unsigned CNT_W = $clog2(SHIFT_W + 1);

  logic [SHIFT_W-1:0] sr_q;
  logic [SHIFT_W-1:0] sr_nxt;
  logic [CNT_W-1:0]   bits_q;
  logic [CNT_W-1:0]   last_idx;
  logic               last;

  assign sr_nxt   = {sdata_i, sr_q[SHIFT_W-1:1]};
  assign last_idx = nine_i ? CNT_W'(SHIFT_W - 1) : CNT_W'(BYTE_W - 1);
  assign last     = (bits_q == last_idx);
  assign done_o   = fall_i && last;

  always_comb begin
    if (nine_i) begin
      word_o.data = sr_nxt[BYTE_W-1:0];
      word_o.bit9 = sr_nxt[SHIFT_W-1];
    end else begin
      word_o.data = sr_nxt[SHIFT_W-1:1];
      word_o.bit9 = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bits_q <= '0;
    end else if (!run_i) begin
      bits_q <= '0;
    end else if (fall_i) begin
      sr_q   <= sr_nxt;
      bits_q <= last ? '0 : bits_q + 1'b1;
    end
  end
endmodule

// File: rtl/smrx_fifo.sv
module smrx_fifo
  import smrx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push_i,
  input  rx_word_t word_i,
  input  logic     pop_i,
  output logic     full_o,
  output logic     empty_o,
  output rx_word_t head_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rx_word_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q;
  logic [PTR_W-1:0] rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rptr_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) begin
        mem_q[wptr_q] <= word_i;
        wptr_q        <= bump(wptr_q);
      end
      if (pop_i) rptr_q <= bump(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
  import smrx_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en_i,
  input  logic              cont_en_i,
  input  logic              single_set_i,
  input  logic              nine_bit_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              irq_en_i,
  output logic              sclk_o,
  input  logic              sdata_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_bit9_o,
  output logic              rx_ready_o,
  output logic              irq_o,
  output logic              overrun_o,
  output logic              single_en_o
);
  logic     single_q;
  logic     cont_q;
  logic     ovr_q;
  logic     run_w;
  logic     fall_w;
  logic     done_w;
  logic     push_w;
  logic     pop_w;
  logic     full_w;
  logic     empty_w;
  rx_word_t word_w;
  rx_word_t head_w;

  assign run_w = port_en_i && (cont_en_i || single_q);

  smrx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_w),
    .div_i  (div_i),
    .sclk_o (sclk_o),
    .fall_o (fall_w)
  );

  smrx_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_w),
    .fall_i  (fall_w),
    .nine_i  (nine_bit_i),
    .sdata_i (sdata_i),
    .done_o  (done_w),
    .word_o  (word_w)
  );

  assign push_w = done_w && !ovr_q && !full_w;
  assign pop_w  = rd_valid_o && rd_ready_i;

  smrx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_w),
    .word_i  (word_w),
    .pop_i   (pop_w),
    .full_o  (full_w),
    .empty_o (empty_w),
    .head_o  (head_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      cont_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      cont_q <= cont_en_i;
      if (single_set_i)  single_q <= 1'b1;
      else if (done_w)   single_q <= 1'b0;
      if (done_w && full_w)            ovr_q <= 1'b1;
      else if (cont_q && !cont_en_i)   ovr_q <= 1'b0;
    end
  end

  assign rd_valid_o  = !empty_w;
  assign rd_data_o   = head_w.data;
  assign rd_bit9_o   = head_w.bit9;
  assign rx_ready_o  = !empty_w;
  assign irq_o       = rx_ready_o && irq_en_i;
  assign overrun_o   = ovr_q;
  assign single_en_o = single_q;
endmodule

// File: rtl/smrx_checker.sv
module smrx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en_i,
  input logic       cont_en_i,
  input logic       single_set_i,
  input logic       single_en_o,
  input logic       sclk_o,
  input logic       overrun_o,
  input logic       rx_ready_o,
  input logic       rd_valid_o,
  input logic       rd_ready_i,
  input logic [7:0] rd_data_o,
  input logic       push_w,
  input logic       done_w
);
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en_i || (!cont_en_i && !single_en_o)) |=> !sclk_o);

  assert_sample_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |-> sclk_o);

  assert_sample_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> !sclk_o);

  assert_single_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && !single_set_i) |=> !single_en_o);

  assert_hold_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  assert_ready_from_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready_o) |-> $past(push_w));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && cont_en_i) |=> overrun_o);

  assert_no_load_in_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> !push_w);
endmodule

bind sync_master_rx smrx_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .port_en_i    (port_en_i),
  .cont_en_i    (cont_en_i),
  .single_set_i (single_set_i),
  .single_en_o  (single_en_o),
  .sclk_o       (sclk_o),
  .overrun_o    (overrun_o),
  .rx_ready_o   (rx_ready_o),
  .rd_valid_o   (rd_valid_o),
  .rd_ready_i   (rd_ready_i),
  .rd_data_o    (rd_data_o),
  .push_w       (push_w),
  .done_w       (done_w)
);

// File: tb/sim_sync_master_rx.sv
`timescale 1ns/1ps
module sim_sync_master_rx;
  localparam int unsigned DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             port_en = 1'b0;
  logic             cont_en = 1'b0;
  logic             single_set = 1'b0;
  logic             nine = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic             irq_en = 1'b0;
  logic             sclk;
  logic             sdata = 1'b0;
  logic             rd_valid;
  logic             rd_ready = 1'b0;
  logic [7:0]       rd_data;
  logic             rd_bit9;
  logic             rx_ready;
  logic             irq;
  logic             overrun;
  logic             single_en;

  sync_master_rx #(.DIV_W(DIV_W), .FIFO_DEPTH(2)) u0 (
    .clk(clk), .rst_n(rst_n), .port_en_i(port_en), .cont_en_i(cont_en),
    .single_set_i(single_set), .nine_bit_i(nine), .div_i(div), .irq_en_i(irq_en),
    .sclk_o(sclk), .sdata_i(sdata), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .rd_data_o(rd_data), .rd_bit9_o(rd_bit9), .rx_ready_o(rx_ready), .irq_o(irq),
    .overrun_o(overrun), .single_en_o(single_en)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  // slave model: next bit is driven after each rising shift-clock edge
  logic tx_bits [0:63];
  int   tx_len = 0;
  int   tx_start = 0;
  int   rise_count = 0;
  int   cyc = 0;
  int   last_rise = 0;
  int   period = 0;
  logic sclk_prev = 1'b0;

  always @(negedge clk) begin
    int idx;
    cyc <= cyc + 1;
    if (sclk && !sclk_prev) begin
      idx = rise_count - tx_start;
      sdata      <= (idx >= 0 && idx < tx_len) ? tx_bits[idx] : 1'b0;
      rise_count <= rise_count + 1;
      period     <= cyc - last_rise;
      last_rise  <= cyc;
    end
    sclk_prev <= sclk;
  end

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !done_flag) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cyc);
      report();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_stream();
    tx_start = rise_count;
    tx_len   = 0;
  endtask

  task automatic add_word(input logic [8:0] w, input int n);
    for (int k = 0; k < n; k++) tx_bits[tx_len + k] = w[k];
    tx_len += n;
  endtask

  task automatic pulse_single();
    @(negedge clk) single_set = 1'b1;
    @(negedge clk) single_set = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk) rd_ready = 1'b1;
    @(negedge clk) rd_ready = 1'b0;
  endtask

  task automatic wait_single_done();
    for (int k = 0; k < 2000 && single_en; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 8 && rd_valid; k++) pop();
  endtask

  // {div[3:0], nine, word[8:0]}
  localparam logic [13:0] VEC [6] = '{
    {4'd0, 1'b0, 9'h0A5},
    {4'd1, 1'b0, 9'h13C},
    {4'd3, 1'b1, 9'h1FF},
    {4'd0, 1'b1, 9'h100},
    {4'd2, 1'b1, 9'h0FE},
    {4'd1, 1'b0, 9'h081}
  };

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 valid", 32'(rd_valid), 0);
    chk("R1 ready", 32'(rx_ready), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 single", 32'(single_en), 0);
    rst_n = 1'b1;
    port_en = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: one-shot words, R3 R4 R10
    for (int v = 0; v < 6; v++) begin
      logic [13:0] e;
      e = VEC[v];
      div  = e[13:10];
      nine = e[9];
      clear_stream();
      add_word(e[8:0], e[9] ? 9 : 8);
      pulse_single();
      wait_single_done();
      chk("R4 single cleared", 32'(single_en), 0);
      chk("R2 sclk idle low", 32'(sclk), 0);
      chk("R6 valid", 32'(rd_valid), 1);
      chk("R3 data", 32'(rd_data), 32'(e[7:0]));
      chk("R10 bit9", 32'(rd_bit9), e[9] ? 32'(e[8]) : 0);
      pop();
      chk("R4 one word only", 32'(rd_valid), 0);
    end

    // R6 back-pressure and R7 flag/irq
    div = 4'd0; nine = 1'b0;
    clear_stream();
    add_word(9'h05A, 8);
    pulse_single();
    wait_single_done();
    repeat (20) @(negedge clk);
    chk("R6 held valid", 32'(rd_valid), 1);
    chk("R6 held data", 32'(rd_data), 32'h5A);
    chk("R7 ready set", 32'(rx_ready), 1);
    chk("R7 irq masked", 32'(irq), 0);
    irq_en = 1'b1;
    #1;
    chk("R7 irq on", 32'(irq), 1);
    pop();
    chk("R7 ready clears", 32'(rx_ready), 0);
    chk("R7 irq clears", 32'(irq), 0);
    irq_en = 1'b0;

    // R2 port disabled: no clock
    port_en = 1'b0; cont_en = 1'b1;
    r0 = rise_count;
    repeat (30) @(negedge clk);
    chk("R2 disabled no edges", 32'(rise_count - r0), 0);
    chk("R2 disabled low", 32'(sclk), 0);
    cont_en = 1'b0;
    @(negedge clk);
    port_en = 1'b1;

    // R2 period with div=2
    div = 4'd2;
    clear_stream();
    cont_en = 1'b1;
    r0 = rise_count;
    for (int k = 0; k < 500 && rise_count < r0 + 3; k++) @(negedge clk);
    @(negedge clk);
    chk("R2 period", 32'(period), 6);
    cont_en = 1'b0;
    repeat (3) @(negedge clk);
    drain();

    // R5 R8 R9: continuous burst with one-shot also set, no reads
    div = 4'd0;
    clear_stream();
    add_word(9'h011, 8); add_word(9'h022, 8);
    add_word(9'h033, 8); add_word(9'h044, 8);
    cont_en = 1'b1;
    pulse_single();
    for (int k = 0; k < 2000 && !overrun; k++) @(negedge clk);
    chk("R8 overrun set", 32'(overrun), 1);
    repeat (40) @(negedge clk);
    chk("R5 single cleared, continuing", 32'(single_en), 0);
    chk("R9 overrun sticky", 32'(overrun), 1);
    chk("R8 first kept", 32'(rd_data), 32'h11);
    pop();
    chk("R8 second kept", 32'(rd_data), 32'h22);
    pop();
    chk("R8 third discarded", 32'(rd_valid), 0);
    repeat (40) @(negedge clk);
    chk("R9 loads blocked", 32'(rd_valid), 0);
    chk("R9 still set", 32'(overrun), 1);
    cont_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 cleared", 32'(overrun), 0);
    chk("R5 stopped", 32'(sclk), 0);

    done_flag = 1'b1;
    report();
  end
endmodule